// File: doc/BRIEF.md
# Line-Address Deadline Timer Table

The block keeps a small set of pending timers, each named by a cache-line address. A client arms a timer by presenting a line address and a relative delay in cycles; the block adds that delay to its own free-running cycle count and stores the resulting absolute deadline. A client can also cancel a pending timer by naming its address.

On the output side, the block always presents the pending entry whose absolute deadline is the smallest. `ready` is raised once the cycle count has reached that deadline, and `readyAddr` names that entry's address. Requests that break the table's rules leave the stored contents untouched and produce a single-cycle `error` pulse. Such requests are:

- a zero delay;
- arming an address that is already armed;
- cancelling an address that is not armed;
- an address with non-zero line-offset bits;
- arming while every slot is occupied.

A typical client is a protocol controller that needs to retry or time out per-line transactions.

Top module: `timer_table`

## Requirements
- R1: After reset the table is empty: `ready`, `full` and `error` are all 0.
- R2: An arm request with delay D accepted at clock edge k stores deadline = count(k) + D. `ready` is 0 through edge k+D-2 and is 1 after edge k+D-1, because the counter advances by one on every edge, including edge k.
- R3: When several timers are pending, `readyAddr` is the address of the entry with the strictly smallest absolute deadline.
- R4: Arming allocates the lowest-numbered free slot. When deadlines are equal, the entry in the lower-numbered slot is reported.
- R5: An arm request with delay 0 is rejected: nothing is stored and `error` pulses.
- R6: Arming an address that is already armed is rejected. The original deadline is kept and `error` pulses.
- R7: Cancelling an address that is not armed is rejected and `error` pulses.
- R8: An address is line-aligned when its low LINE_OFF bits (6 by default) are zero. A set or unset request with any of those bits set is rejected with an `error` pulse and the table is unchanged.
- R9: `full` is 1 exactly when all ENTRIES slots hold a timer. An arm request while full is dropped and `error` pulses.
- R10: A valid cancel removes the entry, and the earliest-entry report moves to the next remaining entry. `ready` is 0 whenever the table is empty.
- R11: `error` is a registered pulse. It is 1 in the cycle after an illegal request and returns to 0 after the next edge if no further illegal request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setValid | input | 1 | Arm request strobe |
| setAddr | input | ADDR_W | Line address to arm |
| setDelay | input | TIME_W | Relative delay in cycles, must be non-zero |
| unsetValid | input | 1 | Cancel request strobe |
| unsetAddr | input | ADDR_W | Line address to cancel |
| ready | output | 1 | Earliest pending deadline has been reached |
| readyAddr | output | ADDR_W | Address owning the earliest deadline |
| full | output | 1 | All slots occupied |
| error | output | 1 | One-cycle pulse after a rejected request |

## Verification
The hardest case to reach is a deadline tie in which the lower-numbered slot was filled later than the higher one. If slots are only ever filled in order, lowest-index tie-breaking cannot be told apart from first-armed tie-breaking. The stimulus therefore arms two addresses with equal absolute deadlines, cancels the one in slot 0, and then arms a third address into the freed slot with a delay chosen so that it lands on the same deadline. The third address must then be reported ahead of the older one.

// File: rtl/tt_pkg.sv
package tt_pkg;
  // Strobes from the request checker to the storage datapath.
  typedef struct packed {
    logic doSet;
    logic doUnset;
  } ttStrobe_t;
endpackage

// File: rtl/tt_ctrl.sv
module tt_ctrl #(
  parameter int ENTRIES  = 8,
  parameter int TIME_W   = 32,
  parameter int LINE_OFF = 6,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                setValid,
  input  logic [LINE_OFF-1:0] setOff,
  input  logic [TIME_W-1:0]   setDelay,
  input  logic                unsetValid,
  input  logic [LINE_OFF-1:0] unsetOff,
  input  logic [ENTRIES-1:0]  setHit,
  input  logic [ENTRIES-1:0]  unsetHit,
  input  logic [ENTRIES-1:0]  freeVec,
  output tt_pkg::ttStrobe_t   strb,
  output logic [IDX_W-1:0]    setSlot,
  output logic [IDX_W-1:0]    unsetSlot,
  output logic                error
);
  logic setOk, unsetOk, setBad, unsetBad, errQ;

  // lowest free slot wins allocation
  always_comb begin
    setSlot = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (freeVec[i]) setSlot = IDX_W'(i);
  end

  // at most one slot can match the cancel address
  always_comb begin
    unsetSlot = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (unsetHit[i]) unsetSlot = IDX_W'(i);
  end

  always_comb begin
    setOk    = setValid && (setOff == '0) && (setDelay != '0)
               && !(|setHit) && (|freeVec);
    unsetOk  = unsetValid && (unsetOff == '0) && (|unsetHit);
    setBad   = setValid && !setOk;
    unsetBad = unsetValid && !unsetOk;
    strb.doSet   = setOk;
    strb.doUnset = unsetOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) errQ <= 1'b0;
    else       errQ <= setBad || unsetBad;
  end

  assign error = errQ;
endmodule

// File: rtl/tt_data.sv
module tt_data #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int TIME_W  = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  tt_pkg::ttStrobe_t  strb,
  input  logic [IDX_W-1:0]   setSlot,
  input  logic [IDX_W-1:0]   unsetSlot,
  input  logic [ADDR_W-1:0]  setAddr,
  input  logic [TIME_W-1:0]  setDelay,
  input  logic [ADDR_W-1:0]  unsetAddr,
  output logic [ENTRIES-1:0] setHit,
  output logic [ENTRIES-1:0] unsetHit,
  output logic [ENTRIES-1:0] freeVec,
  output logic [ENTRIES-1:0] slotValid,
  output logic               ready,
  output logic [ADDR_W-1:0]  readyAddr,
  output logic               full
);
  logic [ADDR_W-1:0] slotAddr [ENTRIES];
  logic [TIME_W-1:0] slotDl   [ENTRIES];
  logic [TIME_W-1:0] nowCnt;
  logic              found;
  logic [IDX_W-1:0]  bestIdx;
  logic [TIME_W-1:0] bestDl;

  always_ff @(posedge clk) begin
    if (!rstN) nowCnt <= '0;
    else       nowCnt <= nowCnt + 1'b1;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : gSlot
    assign setHit[g]   = slotValid[g] && (slotAddr[g] == setAddr);
    assign unsetHit[g] = slotValid[g] && (slotAddr[g] == unsetAddr);
    assign freeVec[g]  = !slotValid[g];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotValid[g] <= 1'b0;
        slotAddr[g]  <= '0;
        slotDl[g]    <= '0;
      end else if (strb.doSet && setSlot == IDX_W'(g)) begin
        slotValid[g] <= 1'b1;
        slotAddr[g]  <= setAddr;
        slotDl[g]    <= nowCnt + setDelay;
      end else if (strb.doUnset && unsetSlot == IDX_W'(g)) begin
        slotValid[g] <= 1'b0;
      end
    end
  end

  // ascending scan: only a strictly smaller deadline displaces the candidate
  always_comb begin
    found   = 1'b0;
    bestIdx = '0;
    bestDl  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (slotValid[i] && (!found || slotDl[i] < bestDl)) begin
        found   = 1'b1;
        bestIdx = IDX_W'(i);
        bestDl  = slotDl[i];
      end
    end
  end

  assign ready     = found && (nowCnt >= bestDl);
  assign readyAddr = found ? slotAddr[bestIdx] : '0;
  assign full      = &slotValid;
endmodule

// File: rtl/timer_table.sv
module timer_table #(
  parameter int ENTRIES  = 8,
  parameter int ADDR_W   = 32,
  parameter int TIME_W   = 32,
  parameter int LINE_OFF = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setValid,
  input  logic [ADDR_W-1:0] setAddr,
  input  logic [TIME_W-1:0] setDelay,
  input  logic              unsetValid,
  input  logic [ADDR_W-1:0] unsetAddr,
  output logic              ready,
  output logic [ADDR_W-1:0] readyAddr,
  output logic              full,
  output logic              error
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  tt_pkg::ttStrobe_t  strb;
  logic [IDX_W-1:0]   setSlot, unsetSlot;
  logic [ENTRIES-1:0] setHit, unsetHit, freeVec, slotValid;

  tt_ctrl #(.ENTRIES(ENTRIES), .TIME_W(TIME_W), .LINE_OFF(LINE_OFF)) uCtrl (
    .clk(clk), .rstN(rstN),
    .setValid(setValid), .setOff(setAddr[LINE_OFF-1:0]), .setDelay(setDelay),
    .unsetValid(unsetValid), .unsetOff(unsetAddr[LINE_OFF-1:0]),
    .setHit(setHit), .unsetHit(unsetHit), .freeVec(freeVec),
    .strb(strb), .setSlot(setSlot), .unsetSlot(unsetSlot), .error(error)
  );

  tt_data #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .TIME_W(TIME_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .setSlot(setSlot), .unsetSlot(unsetSlot),
    .setAddr(setAddr), .setDelay(setDelay), .unsetAddr(unsetAddr),
    .setHit(setHit), .unsetHit(unsetHit), .freeVec(freeVec),
    .slotValid(slotValid), .ready(ready), .readyAddr(readyAddr), .full(full)
  );
endmodule

// File: rtl/timer_table_chk.sv
module timer_table_chk #(
  parameter int ENTRIES  = 8,
  parameter int ADDR_W   = 32,
  parameter int TIME_W   = 32,
  parameter int LINE_OFF = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               setValid,
  input logic [ADDR_W-1:0]  setAddr,
  input logic [TIME_W-1:0]  setDelay,
  input logic               unsetValid,
  input logic               ready,
  input logic [ADDR_W-1:0]  readyAddr,
  input logic               full,
  input logic               error,
  input logic [ENTRIES-1:0] slotValid
);
  p_zero_delay_err_r5: assert property (@(posedge clk) disable iff (!rstN)
    (setValid && setDelay == '0) |=> error);

  p_misaligned_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    (setValid && setAddr[LINE_OFF-1:0] != '0) |=> error);

  p_aligned_out_r8: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (readyAddr[LINE_OFF-1:0] == '0));

  p_full_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (full && setValid) |=> error);

  p_empty_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid == '0) |-> !ready);

  p_err_cause_r11: assert property (@(posedge clk) disable iff (!rstN)
    error |-> $past(setValid || unsetValid));
endmodule

bind timer_table timer_table_chk #(
  .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .TIME_W(TIME_W), .LINE_OFF(LINE_OFF)
) uChk (
  .clk(clk), .rstN(rstN), .setValid(setValid), .setAddr(setAddr),
  .setDelay(setDelay), .unsetValid(unsetValid), .ready(ready),
  .readyAddr(readyAddr), .full(full), .error(error), .slotValid(slotValid)
);

// File: tb/tb_timer_table.sv
module tb_timer_table;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 8;
  localparam int ADDR_W = 32;
  localparam int TIME_W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic setValid = 1'b0;
  logic [ADDR_W-1:0] setAddr = '0;
  logic [TIME_W-1:0] setDelay = '0;
  logic unsetValid = 1'b0;
  logic [ADDR_W-1:0] unsetAddr = '0;
  logic ready, full, error;
  logic [ADDR_W-1:0] readyAddr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  timer_table dut (
    .clk(clk), .rstN(rstN), .setValid(setValid), .setAddr(setAddr),
    .setDelay(setDelay), .unsetValid(unsetValid), .unsetAddr(unsetAddr),
    .ready(ready), .readyAddr(readyAddr), .full(full), .error(error)
  );

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic armT(input logic [ADDR_W-1:0] a, input logic [TIME_W-1:0] d);
    setValid = 1'b1; setAddr = a; setDelay = d;
    step();
    setValid = 1'b0;
  endtask

  task automatic cancelT(input logic [ADDR_W-1:0] a);
    unsetValid = 1'b1; unsetAddr = a;
    step();
    unsetValid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 ready", ready, 0);
    chk("R1 full", full, 0);
    chk("R1 error", error, 0);
  endtask

  task automatic t_deadline;
    armT(32'h100, 4);
    chk("R2 no error", error, 0);
    step(2);
    chk("R2 not yet", ready, 0);
    step();
    chk("R2 due", ready, 1);
    chk("R2 addr", readyAddr, 32'h100);
    cancelT(32'h100);
    chk("R10 empty", ready, 0);
    armT(32'h140, 1);
    chk("R2 delay1 due", ready, 1);
    cancelT(32'h140);
    chk("R10 empty2", ready, 0);
  endtask

  task automatic t_earliest;
    armT(32'h200, 20);
    armT(32'h240, 8);
    armT(32'h280, 30);
    step(5);
    chk("R3 not yet", ready, 0);
    step();
    chk("R3 earliest ready", ready, 1);
    chk("R3 earliest addr", readyAddr, 32'h240);
    cancelT(32'h240);
    chk("R10 next not due", ready, 0);
    step(15);
    chk("R3 second", readyAddr, 32'h200);
    chk("R3 second ready", ready, 1);
    cancelT(32'h200);
    step(15);
    chk("R10 third", readyAddr, 32'h280);
    cancelT(32'h280);
    chk("R10 drained", ready, 0);
  endtask

  task automatic t_tie;
    armT(32'h300, 10);
    armT(32'h340, 9);
    cancelT(32'h300);
    armT(32'h380, 7);
    step(5);
    chk("R4 tie not yet", ready, 0);
    step();
    chk("R4 tie ready", ready, 1);
    chk("R4 lowest slot wins", readyAddr, 32'h380);
    cancelT(32'h380);
    chk("R4 other tie", readyAddr, 32'h340);
    cancelT(32'h340);
    armT(32'h400, 6);
    armT(32'h440, 5);
    step(4);
    chk("R4 tie slot0", readyAddr, 32'h400);
    cancelT(32'h400);
    cancelT(32'h440);
  endtask

  task automatic t_illegal;
    armT(32'h500, 0);
    chk("R5 zero err", error, 1);
    step();
    chk("R11 pulse ends", error, 0);
    cancelT(32'h500);
    chk("R7 absent err", error, 1);
    chk("R5 nothing stored", ready, 0);
    step();
    armT(32'h540, 3);
    armT(32'h540, 40);
    chk("R6 dup err", error, 1);
    step();
    chk("R6 original kept", ready, 1);
    chk("R6 addr", readyAddr, 32'h540);
    cancelT(32'h540);
    chk("R6 cancel ok", error, 0);
    armT(32'h584, 2);
    chk("R8 misaligned set", error, 1);
    cancelT(32'h580);
    chk("R8 nothing stored", error, 1);
    armT(32'h5c0, 2);
    cancelT(32'h5c4);
    chk("R8 misaligned unset", error, 1);
    step();
    chk("R8 entry kept", readyAddr, 32'h5c0);
    chk("R8 entry ready", ready, 1);
    cancelT(32'h5c0);
  endtask

  task automatic t_full;
    for (int i = 0; i < ENTRIES; i++) begin
      chk("R9 not full", full, 0);
      armT(32'h1000 + i * 32'h40, 100);
    end
    chk("R9 full", full, 1);
    armT(32'h2000, 1);
    chk("R9 drop err", error, 1);
    chk("R9 still full", full, 1);
    step(2);
    chk("R9 dropped", ready, 0);
    for (int i = 0; i < ENTRIES; i++) cancelT(32'h1000 + i * 32'h40);
    chk("R9 empty full", full, 0);
    chk("R10 empty ready", ready, 0);
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step();
    t_reset();
    t_deadline();
    t_earliest();
    t_tie();
    t_illegal();
    t_full();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule